// File: doc/BRIEF.md
# Mixed-Length Instruction Predecode Aligner

The aligner sits between instruction fetch and decode in a core whose instruction stream can be in one of two encodings. In full-width mode every 32-bit fetch word is exactly one instruction. In compressed mode the stream is a run of halfwords. Each compressed instruction is either a single 16-bit halfword or a 32-bit instruction built from two halfwords. The two halves of a 32-bit instruction may sit in different fetch words.

The block takes one fetch word at a time on a valid/ready handshake. It keeps a byte offset into that word and works through it one instruction per step. It presents each assembled instruction on a second valid/ready handshake, along with:
- its size,
- its own address and the address that follows it,
- a 4-bit condition field,
- two predecode flags for full-width instructions.

When a 32-bit compressed instruction starts in the upper halfword of a word, the first half is parked. It is completed from the low halfword of the next word. The fetch side is asked for a new word only once the current one is used up.

The encoding mode and an 8-bit conditional-block state are sampled with each fetch word. The top four bits of that state are passed along as the condition field of 32-bit compressed instructions.

Top module: `pdal_aligner`

## Requirements
- R1: After reset, `out_valid` is 0, `ins_bits` is 0, and `fw_ready` is 1, meaning the block needs bytes.
- R2: `fw_ready` is 1 exactly when every byte of the held fetch word has been used (the offset reaches 4, never beyond). A word is accepted only on a cycle where `fw_valid` and `fw_ready` are both 1. Accepting a word drops `fw_ready` at the next edge and resets the offset to 0. While `fw_ready` is 0, `fw_data` is ignored. `fw_cmp` and `fw_cblk` are sampled only when a word is accepted.
- R3: Full-width mode (word loaded with `fw_cmp` = 0) produces one instruction per word, with these outputs:
  - `ins_bits` is the whole word and `ins_size` is 4.
  - `ins_cond` is word bits [31:28].
  - `ins_sf` is bit 7 AND bit 4.
  - `ins_misc` is 1 when bits [24:23] = 2'b10 and bit 20 = 0.
  
  Both flags are 0 for every compressed instruction.
- R4: In compressed mode the current halfword is the fetch word shifted right by offset×8 bits, so the low halfword comes before the high one. A halfword that is not a first half (R5) is a 16-bit instruction. Its outputs are:
  - `ins_bits` is the halfword zero-extended.
  - `ins_size` is 2.
  - `ins_cond` is forced to the unconditional code 4'hF.
- R5: A halfword is the first half of a 32-bit compressed instruction exactly when its bits [15:11] are 5'b11101, 5'b11110 or 5'b11111. Any other value, such as 5'b11100, is a 16-bit instruction.
- R6: A first half found at offset 0 makes a complete 32-bit instruction from the whole word, with its halfwords swapped: `ins_bits` = {word[15:0], word[31:16]}. Its `ins_size` is 4 and its `ins_cond` is `fw_cblk`[7:4] of that word.
- R7: A first half found at offset 2 produces no output and uses up the word. With the next word, that halfword becomes `ins_bits`[31:16] and the next word's low halfword becomes `ins_bits`[15:0]. `ins_size` is 4. `ins_pc` is the address of the first half. `ins_cond` comes from the `fw_cblk` of the first word.
- R8: While `out_valid` is 1 and `out_ready` is 0, all instruction outputs hold steady. A take (`out_valid` and `out_ready` both 1) clears `out_valid` and `ins_bits` to 0 at that edge.
- R9: While `out_valid` is 1, `ins_npc` equals `ins_pc` + `ins_size`. `ins_pc` is the fetch word address plus the offset of the instruction's first byte.
- R10: An instruction is presented one clock edge after the edge that loaded its word. The next instruction from the same word is presented one edge after the take.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fw_valid | input | 1 | Fetch word offered |
| fw_ready | output | 1 | Out of bytes: a new fetch word may be loaded |
| fw_data | input | 32 | Fetch word |
| fw_addr | input | ADDR_W | Byte address of the fetch word (word aligned) |
| fw_cmp | input | 1 | Mode for this word: 1 compressed, 0 full-width |
| fw_cblk | input | CBLK_W | Conditional-block state latched with the word |
| out_valid | output | 1 | Assembled instruction ready |
| out_ready | input | 1 | Consumer takes the instruction |
| ins_bits | output | 32 | Assembled instruction |
| ins_size | output | 3 | Instruction size in bytes (2 or 4) |
| ins_pc | output | ADDR_W | Address of the instruction |
| ins_npc | output | ADDR_W | Address of the following instruction |
| ins_cond | output | 4 | Condition field |
| ins_sf | output | 1 | Full-width flag: bit 7 AND bit 4 |
| ins_misc | output | 1 | Full-width flag: miscellaneous-group pattern |

## Verification
A wrong offset or out-of-bytes register shows up within one or two instructions at the ports, in any of these ways:
- a repeated or skipped halfword;
- an `ins_pc` that does not follow the previous `ins_npc`;
- `fw_ready` rising early, which swallows a word, or never rising, which hangs the stream.

A pending flag that is left set or wrongly cleared corrupts the very next compressed instruction. Its upper halfword is then either stale or zero, and its size or address is off. This is why the straddling cases are checked across two words, including a boundary prefix value on each side of the decision. Stalls on the output are mixed into the stream so that a take that fails to clear the held instruction, or a step that overruns it, appears as a changed value during the hold.

// File: rtl/pdal_pkg.sv
package pdal_pkg;
   localparam int unsigned WORD_W     = 32;
   localparam int unsigned HALF_W     = WORD_W / 2;
   localparam int unsigned WORD_BYTES = WORD_W / 8;
   localparam int unsigned OFF_W      = $clog2(WORD_BYTES) + 1;

   typedef logic [OFF_W-1:0] off_t;

   typedef struct packed {
      logic [WORD_W-1:0] bits;
      logic [3:0]        cond;
      logic              sf;
      logic              misc;
      logic [2:0]        size;
   } ins_t;
endpackage

// File: rtl/pdal_hw_pick.sv
module pdal_hw_pick
   import pdal_pkg::*;
#(
   parameter logic [4:0] PREFIX_MIN = 5'b11101
) (
   input  logic [WORD_W-1:0] word,
   input  off_t              off,
   output logic [HALF_W-1:0] hw,
   output logic              first_half
);
   logic [WORD_W-1:0] shifted;

   always_comb begin
      shifted    = word >> {off, 3'b000};
      hw         = shifted[HALF_W-1:0];
      first_half = (hw[HALF_W-1:HALF_W-5] >= PREFIX_MIN);
   end
endmodule

// File: rtl/pdal_full_flags.sv
module pdal_full_flags
   import pdal_pkg::*;
#(
   parameter bit EN_FLAGS = 1'b1
) (
   input  logic [WORD_W-1:0] word,
   output logic              sf,
   output logic              misc
);
   if (EN_FLAGS) begin : g_flags
      assign sf   = word[7] & word[4];
      assign misc = (word[24:23] == 2'b10) & ~word[20];
   end else begin : g_noflags
      assign sf   = 1'b0;
      assign misc = 1'b0;
   end
endmodule

// File: rtl/pdal_step.sv
module pdal_step
   import pdal_pkg::*;
#(
   parameter int unsigned ADDR_W      = 32,
   parameter int unsigned CBLK_W      = 8,
   parameter logic [3:0]  UNCOND_CODE = 4'hF,
   parameter logic [4:0]  PREFIX_MIN  = 5'b11101,
   parameter bit          EN_FLAGS    = 1'b1
) (
   input  logic [WORD_W-1:0] word,
   input  logic [ADDR_W-1:0] base_addr,
   input  off_t              off,
   input  logic              cmp,
   input  logic [CBLK_W-1:0] cblk,
   input  logic              pend,
   input  logic [HALF_W-1:0] hold_hi,
   input  logic [ADDR_W-1:0] hold_pc,
   input  logic [3:0]        hold_cond,
   output ins_t              nins,
   output logic [ADDR_W-1:0] npc,
   output logic [2:0]        consume,
   output logic              done,
   output logic              set_pend,
   output logic [HALF_W-1:0] park_hw,
   output logic [ADDR_W-1:0] park_pc,
   output logic [3:0]        park_cond
);
   logic [HALF_W-1:0] hw;
   logic              first_half;
   logic              sf, misc;
   logic [ADDR_W-1:0] cur_pc;
   logic [3:0]        cblk_cond;

   pdal_hw_pick #(.PREFIX_MIN(PREFIX_MIN)) i_pick (
      .word(word), .off(off), .hw(hw), .first_half(first_half)
   );

   pdal_full_flags #(.EN_FLAGS(EN_FLAGS)) i_flags (
      .word(word), .sf(sf), .misc(misc)
   );

   always_comb begin
      cur_pc    = base_addr + ADDR_W'(off);
      cblk_cond = cblk[CBLK_W-1 -: 4];
      nins      = '0;
      npc       = cur_pc;
      consume   = 3'd2;
      done      = 1'b1;
      set_pend  = 1'b0;
      park_hw   = hw;
      park_pc   = cur_pc;
      park_cond = cblk_cond;
      if (pend) begin
         nins.bits = {hold_hi, hw};
         nins.cond = hold_cond;
         nins.size = 3'd4;
         npc       = hold_pc;
      end else if (!cmp) begin
         nins.bits = word;
         nins.cond = word[WORD_W-1 -: 4];
         nins.sf   = sf;
         nins.misc = misc;
         nins.size = 3'd4;
         consume   = 3'd4;
      end else if (first_half && off == '0) begin
         nins.bits = {word[HALF_W-1:0], word[WORD_W-1:HALF_W]};
         nins.cond = cblk_cond;
         nins.size = 3'd4;
         consume   = 3'd4;
      end else if (first_half) begin
         done     = 1'b0;
         set_pend = 1'b1;
      end else begin
         nins.bits = {{HALF_W{1'b0}}, hw};
         nins.cond = UNCOND_CODE;
         nins.size = 3'd2;
      end
   end
endmodule

// File: rtl/pdal_aligner.sv
module pdal_aligner
   import pdal_pkg::*;
#(
   parameter int unsigned ADDR_W      = 32,
   parameter int unsigned CBLK_W      = 8,
   parameter logic [3:0]  UNCOND_CODE = 4'hF,
   parameter logic [4:0]  PREFIX_MIN  = 5'b11101,
   parameter bit          EN_FLAGS    = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              fw_valid,
   output logic              fw_ready,
   input  logic [31:0]       fw_data,
   input  logic [ADDR_W-1:0] fw_addr,
   input  logic              fw_cmp,
   input  logic [CBLK_W-1:0] fw_cblk,
   output logic              out_valid,
   input  logic              out_ready,
   output logic [31:0]       ins_bits,
   output logic [2:0]        ins_size,
   output logic [ADDR_W-1:0] ins_pc,
   output logic [ADDR_W-1:0] ins_npc,
   output logic [3:0]        ins_cond,
   output logic              ins_sf,
   output logic              ins_misc
);
   if (ADDR_W < 3) begin : g_bad_addr
      $error("pdal_aligner: ADDR_W must be at least 3");
   end
   if (CBLK_W < 4) begin : g_bad_cblk
      $error("pdal_aligner: CBLK_W must be at least 4");
   end

   localparam int unsigned SUM_W = OFF_W + 1;

   logic [WORD_W-1:0] word_q;
   logic [ADDR_W-1:0] addr_q;
   logic              cmp_q;
   logic [CBLK_W-1:0] cblk_q;
   off_t              off_q;
   logic              oob_q;
   logic              pend_q;
   logic [HALF_W-1:0] hold_hi_q;
   logic [ADDR_W-1:0] hold_pc_q;
   logic [3:0]        hold_cond_q;
   ins_t              ins_q;
   logic [ADDR_W-1:0] pc_q;
   logic              rdy_q;

   ins_t              nins;
   logic [ADDR_W-1:0] step_pc;
   logic [2:0]        consume;
   logic              done, set_pend;
   logic [HALF_W-1:0] park_hw;
   logic [ADDR_W-1:0] park_pc;
   logic [3:0]        park_cond;
   logic [SUM_W-1:0]  off_sum;
   logic              load, step, take;

   pdal_step #(
      .ADDR_W(ADDR_W), .CBLK_W(CBLK_W), .UNCOND_CODE(UNCOND_CODE),
      .PREFIX_MIN(PREFIX_MIN), .EN_FLAGS(EN_FLAGS)
   ) i_step (
      .word(word_q), .base_addr(addr_q), .off(off_q), .cmp(cmp_q),
      .cblk(cblk_q), .pend(pend_q), .hold_hi(hold_hi_q),
      .hold_pc(hold_pc_q), .hold_cond(hold_cond_q),
      .nins(nins), .npc(step_pc), .consume(consume), .done(done),
      .set_pend(set_pend), .park_hw(park_hw), .park_pc(park_pc),
      .park_cond(park_cond)
   );

   always_comb begin
      load    = fw_valid & oob_q;
      step    = ~oob_q & ~rdy_q;
      take    = rdy_q & out_ready;
      off_sum = SUM_W'(off_q) + SUM_W'(consume);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         word_q      <= '0;
         addr_q      <= '0;
         cmp_q       <= 1'b0;
         cblk_q      <= '0;
         off_q       <= '0;
         oob_q       <= 1'b1;
         pend_q      <= 1'b0;
         hold_hi_q   <= '0;
         hold_pc_q   <= '0;
         hold_cond_q <= '0;
         ins_q       <= '0;
         pc_q        <= '0;
         rdy_q       <= 1'b0;
      end else begin
         if (load) begin
            word_q <= fw_data;
            addr_q <= fw_addr;
            cmp_q  <= fw_cmp;
            cblk_q <= fw_cblk;
            off_q  <= '0;
            oob_q  <= 1'b0;
         end
         if (step) begin
            off_q  <= off_sum[OFF_W-1:0];
            oob_q  <= (off_sum >= SUM_W'(WORD_BYTES));
            pend_q <= set_pend;
            if (set_pend) begin
               hold_hi_q   <= park_hw;
               hold_pc_q   <= park_pc;
               hold_cond_q <= park_cond;
            end
            if (done) begin
               ins_q <= nins;
               pc_q  <= step_pc;
               rdy_q <= 1'b1;
            end
         end
         if (take) begin
            ins_q <= '0;
            rdy_q <= 1'b0;
         end
      end
   end

   always_comb begin
      fw_ready  = oob_q;
      out_valid = rdy_q;
      ins_bits  = ins_q.bits;
      ins_size  = ins_q.size;
      ins_cond  = ins_q.cond;
      ins_sf    = ins_q.sf;
      ins_misc  = ins_q.misc;
      ins_pc    = pc_q;
      ins_npc   = pc_q + ADDR_W'(ins_q.size);
   end
endmodule

// File: rtl/pdal_checks.sv
module pdal_checks
   import pdal_pkg::*;
#(
   parameter int unsigned ADDR_W      = 32,
   parameter logic [3:0]  UNCOND_CODE = 4'hF
) (
   input logic              clk,
   input logic              rst_n,
   input logic              fw_valid,
   input logic              fw_ready,
   input logic              out_valid,
   input logic              out_ready,
   input logic [31:0]       ins_bits,
   input logic [2:0]        ins_size,
   input logic [ADDR_W-1:0] ins_pc,
   input logic [ADDR_W-1:0] ins_npc,
   input logic [3:0]        ins_cond,
   input logic              ins_sf,
   input logic              ins_misc,
   input off_t              off_q
);
   AST_OFFSET_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
      off_q <= off_t'(WORD_BYTES)); // R2
   AST_LOAD_CLEARS_NEED: assert property (@(posedge clk) disable iff (!rst_n)
      fw_valid && fw_ready |=> !fw_ready); // R2
   AST_FLAGS_WIDE_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
      (ins_sf || ins_misc) |-> out_valid && ins_size == 3'd4); // R3
   AST_SHORT_FORM: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && ins_size == 3'd2 |-> ins_bits[31:16] == 16'h0 && ins_cond == UNCOND_CODE); // R4
   AST_SIZE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> ins_size == 3'd2 || ins_size == 3'd4); // R4
   AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && !out_ready |=> out_valid && $stable(ins_bits) && $stable(ins_pc) && $stable(ins_cond)); // R8
   AST_TAKE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && out_ready |=> !out_valid && ins_bits == 32'h0); // R8
   AST_NEXT_PC: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> ins_npc == ins_pc + ADDR_W'(ins_size)); // R9
endmodule

bind pdal_aligner pdal_checks #(.ADDR_W(ADDR_W), .UNCOND_CODE(UNCOND_CODE)) i_pdal_checks (
   .clk(clk), .rst_n(rst_n), .fw_valid(fw_valid), .fw_ready(fw_ready),
   .out_valid(out_valid), .out_ready(out_ready), .ins_bits(ins_bits),
   .ins_size(ins_size), .ins_pc(ins_pc), .ins_npc(ins_npc),
   .ins_cond(ins_cond), .ins_sf(ins_sf), .ins_misc(ins_misc), .off_q(off_q)
);

// File: tb/test_pdal_aligner.sv
module test_pdal_aligner;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        fw_valid = 1'b0;
   logic        fw_ready;
   logic [31:0] fw_data = '0;
   logic [31:0] fw_addr = '0;
   logic        fw_cmp = 1'b0;
   logic [7:0]  fw_cblk = '0;
   logic        out_valid;
   logic        out_ready = 1'b0;
   logic [31:0] ins_bits;
   logic [2:0]  ins_size;
   logic [31:0] ins_pc, ins_npc;
   logic [3:0]  ins_cond;
   logic        ins_sf, ins_misc;

   int checks = 0;
   int errors = 0;
   bit finished = 1'b0;

   always #4 clk = ~clk;

   pdal_aligner i_pdal_aligner (
      .clk(clk), .rst_n(rst_n), .fw_valid(fw_valid), .fw_ready(fw_ready),
      .fw_data(fw_data), .fw_addr(fw_addr), .fw_cmp(fw_cmp), .fw_cblk(fw_cblk),
      .out_valid(out_valid), .out_ready(out_ready), .ins_bits(ins_bits),
      .ins_size(ins_size), .ins_pc(ins_pc), .ins_npc(ins_npc),
      .ins_cond(ins_cond), .ins_sf(ins_sf), .ins_misc(ins_misc)
   );

   // fetch words: {cmp, cblk, addr, data}
   localparam int NW = 10;
   localparam logic [72:0] WTAB [NW] = '{
      {1'b0, 8'h00, 32'h100, 32'hE1A00090},
      {1'b0, 8'h00, 32'h104, 32'hE1000000},
      {1'b1, 8'h00, 32'h108, 32'h46082001},
      {1'b1, 8'hA5, 32'h10C, 32'hF800F000},
      {1'b1, 8'h30, 32'h110, 32'hE92DBF00},
      {1'b1, 8'h00, 32'h114, 32'h21004FF0},
      {1'b1, 8'h70, 32'h118, 32'h8000F8FF},
      {1'b0, 8'h00, 32'h11C, 32'h00000000},
      {1'b1, 8'h90, 32'h120, 32'hE800E7FF},
      {1'b1, 8'h00, 32'h124, 32'h00001234}
   };

   // expected: {bits, size, pc, cond, sf, misc, req}
   localparam int NE = 13;
   localparam logic [76:0] ETAB [NE] = '{
      {32'hE1A00090, 3'd4, 32'h100, 4'hE, 1'b1, 1'b0, 4'd3},  // R3 sf set
      {32'hE1000000, 3'd4, 32'h104, 4'hE, 1'b0, 1'b1, 4'd3},  // R3 misc set
      {32'h00002001, 3'd2, 32'h108, 4'hF, 1'b0, 1'b0, 4'd4},  // R4 low half first
      {32'h00004608, 3'd2, 32'h10A, 4'hF, 1'b0, 1'b0, 4'd4},  // R4 high half
      {32'hF000F800, 3'd4, 32'h10C, 4'hA, 1'b0, 1'b0, 4'd6},  // R6 swap
      {32'h0000BF00, 3'd2, 32'h110, 4'hF, 1'b0, 1'b0, 4'd4},  // R4
      {32'hE92D4FF0, 3'd4, 32'h112, 4'h3, 1'b0, 1'b0, 4'd7},  // R7 straddle
      {32'h00002100, 3'd2, 32'h116, 4'hF, 1'b0, 1'b0, 4'd4},  // R4 after join
      {32'hF8FF8000, 3'd4, 32'h118, 4'h7, 1'b0, 1'b0, 4'd5},  // R5 prefix 11111
      {32'h00000000, 3'd4, 32'h11C, 4'h0, 1'b0, 1'b0, 4'd2},  // R2 mode resampled
      {32'h0000E7FF, 3'd2, 32'h120, 4'hF, 1'b0, 1'b0, 4'd5},  // R5 prefix 11100 is short
      {32'hE8001234, 3'd4, 32'h122, 4'h9, 1'b0, 1'b0, 4'd7},  // R7 prefix 11101 straddle
      {32'h00000000, 3'd2, 32'h126, 4'hF, 1'b0, 1'b0, 4'd4}   // R4
   };

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   task automatic push(input logic cmp, input logic [7:0] cblk,
                       input logic [31:0] addr, input logic [31:0] data);
      @(negedge clk);
      while (!fw_ready) @(negedge clk);
      fw_valid = 1'b1; fw_cmp = cmp; fw_cblk = cblk; fw_addr = addr; fw_data = data;
      @(negedge clk);
      fw_valid = 1'b0;
   endtask

   task automatic pop(input logic [76:0] e, input int stall);
      string req;
      int n = 0;
      req = $sformatf("R%0d", e[3:0]);
      while (!out_valid && n < 300) begin @(negedge clk); n++; end
      chk(out_valid, "R10", "valid seen", 32'(out_valid), 32'd1);
      chk(ins_bits == e[76:45], req, "bits", ins_bits, e[76:45]);
      chk(ins_size == e[44:42], req, "size", 32'(ins_size), 32'(e[44:42]));
      chk(ins_pc == e[41:10], req, "pc", ins_pc, e[41:10]);
      chk(ins_npc == e[41:10] + 32'(e[44:42]), "R9", "npc", ins_npc, e[41:10] + 32'(e[44:42]));
      chk(ins_cond == e[9:6], req, "cond", 32'(ins_cond), 32'(e[9:6]));
      chk({ins_sf, ins_misc} == e[5:4], "R3", "flags", 32'({ins_sf, ins_misc}), 32'(e[5:4]));
      for (int s = 0; s < stall; s++) begin
         @(negedge clk);
         chk(out_valid && ins_bits == e[76:45], "R8", "held during stall", ins_bits, e[76:45]);
      end
      out_ready = 1'b1;
      @(negedge clk);
      out_ready = 1'b0;
      chk(!out_valid && ins_bits == 32'h0, "R8", "cleared by take", ins_bits, 32'h0);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         checks++; errors++;
         $display("FAIL R10 watchdog expired: actual hung expected done");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk(!out_valid, "R1", "out_valid after reset", 32'(out_valid), 32'd0);
      chk(ins_bits == 32'h0, "R1", "ins_bits after reset", ins_bits, 32'h0);
      chk(fw_ready, "R1", "needs bytes after reset", 32'(fw_ready), 32'd1);

      // R10 latency, R2 ready handling, R3 flags clear
      fw_valid = 1'b1; fw_cmp = 1'b0; fw_cblk = 8'h00; fw_addr = 32'h200; fw_data = 32'h12345678;
      @(negedge clk);
      fw_valid = 1'b0;
      chk(!fw_ready, "R2", "ready drops after load", 32'(fw_ready), 32'd0);
      chk(!out_valid, "R10", "not valid on load edge", 32'(out_valid), 32'd0);
      @(negedge clk);
      chk(out_valid, "R10", "valid one edge after load", 32'(out_valid), 32'd1);
      chk(fw_ready, "R2", "ready once word used", 32'(fw_ready), 32'd1);
      pop({32'h12345678, 3'd4, 32'h200, 4'h1, 1'b0, 1'b0, 4'd3}, 0);

      // table stream with output stalls
      fork
         begin
            for (int i = 0; i < NW; i++)
               push(WTAB[i][72], WTAB[i][71:64], WTAB[i][63:32], WTAB[i][31:0]);
         end
         begin
            for (int i = 0; i < NE; i++) pop(ETAB[i], i % 3);
         end
      join

      // R2: a word offered while bytes remain is ignored
      push(1'b1, 8'h00, 32'h300, 32'h20022001);
      fw_valid = 1'b1; fw_data = 32'hFFFFFFFF; fw_addr = 32'h400; fw_cmp = 1'b0;
      repeat (3) @(negedge clk);
      chk(!fw_ready, "R2", "no request while bytes remain", 32'(fw_ready), 32'd0);
      fw_valid = 1'b0;
      pop({32'h00002001, 3'd2, 32'h300, 4'hF, 1'b0, 1'b0, 4'd2}, 1);
      pop({32'h00002002, 3'd2, 32'h302, 4'hF, 1'b0, 1'b0, 4'd2}, 0);
      chk(fw_ready, "R2", "request after word used", 32'(fw_ready), 32'd1);
      repeat (2) @(negedge clk);
      chk(!out_valid, "R2", "ignored word produced nothing", 32'(out_valid), 32'd0);

      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule